// File: doc/BRIEF.md
# Word-Wide Host Bus Slave with Wait Handshake

This block is the host-facing port of a display controller's register space. An external processor reaches it over an asynchronous, SRAM-style bus. The bus has an active-low chip select, a word address, active-low byte enables, separate active-low read and write strobes and a shared 32-bit bidirectional data bus. The slave answers on a ready line. Ready falls as soon as chip select is applied and stays low until the internal access has finished. The host therefore holds its strobe and waits, however long the access inside takes.

The strobes and chip select enter the core clock domain through a synchronizer. When a strobe is seen, the slave captures the address, the byte enables and (for a write) the data bus. It then hands one request to a word-wide register store. The store's reply time is set through a latency input, so that waits of different lengths can be produced. The data bus is driven outward only while a completed read is still being strobed. A host that drops chip select early leaves the slave clean, ready for the next access.

Top module: `hbs_host_slave`

## Requirements
- R1: While chip select (active low) is asserted and the current access has not completed, `host_rdy` is low; it is low from the moment chip select is applied, without waiting for a clock edge.
- R2: A read returns on `host_data` the word last written to that address.
- R3: With `cfg_lat` = L (a value of 0 acts as 1), ready rises exactly SYNC_STAGES + L + 2 rising clock edges after the strobe is applied, given that chip select was asserted at least SYNC_STAGES + 1 cycles earlier.
- R4: Byte enable bit i (active low) selects data bits 8i+7..8i; a write changes only the enabled byte lanes of the addressed word.
- R5: The slave drives `host_data` only while chip select and the read strobe are both low after a read has completed; it stops in the same cycle that either is released, and during a write the bus is an input that supplies the stored data.
- R6: If chip select is removed before a read completes, the cycle ends: ready is high while chip select is inactive, and stored data and later accesses are unaffected.
- R7: The register region covers the first 4 KB; a word address with any of bits 23..12 set is outside it. A write there is discarded and a read there returns 0.
- R8: Only one access is made per chip-select assertion; further strobes before chip select is seen inactive have no effect.
- R9: After reset, with chip select inactive, `host_rdy` is high.
- R10: The internal store acknowledges each request exactly L clock edges after accepting it (L as in R3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Chip select, active low |
| host_addr | input | 22 | Word address, byte address bits 23..2 |
| host_be_n | input | 4 | Byte lane enables, active low |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_data | inout | 32 | Bidirectional data bus |
| host_rdy | output | 1 | Ready; low means the host must wait |
| cfg_lat | input | 4 | Internal access latency in cycles (0 treated as 1) |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer, a 4 KB register region and a 4-bit latency field. The two-stage synchronizer makes the ready delay an exact, predictable count, so every access checks that count for latencies 1, 7, 15 and 0. The 4 KB region leaves word addresses above bit 11 free, so an out-of-region address that aliases an in-region word shows whether writes outside the region are dropped. The 15-cycle maximum latency gives a wide window in which chip select can be withdrawn during a read.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int ADDR_LO = 2;
    localparam int ADDR_HI = 23;
    localparam int WADDR_W = ADDR_HI - ADDR_LO + 1;

    // Front-end sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,   // chip select not seen
        ST_ARMED,  // chip select seen, waiting for a strobe
        ST_BUSY,   // request issued, waiting for the store
        ST_DONE,   // access complete, strobe still held
        ST_HOLD    // strobe released, waiting for chip select to drop
    } hbs_state_e;

    // One request toward the register store
    typedef struct packed {
        logic                 write;
        logic [WADDR_W-1:0]   waddr;
        logic [LANES-1:0]     lane_en;
        logic [DATA_W-1:0]    wdata;
    } hbs_req_t;

    // True when the word address falls inside the register region
    function automatic logic in_region(input logic [WADDR_W-1:0] a, input int idx_w);
        return (a >> idx_w) == '0;
    endfunction

endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hbs_frontend.sv
module hbs_frontend
    import hbs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_s,
    input  logic                rd_s,
    input  logic                wr_s,
    input  logic [WADDR_W-1:0]  addr,
    input  logic [LANES-1:0]    be_n,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                mem_ack,
    output logic                req_valid,
    output hbs_req_t            req,
    output logic                done_q,
    output logic                oe_q,
    output hbs_state_e          state_q
);
    hbs_state_e state_d;
    logic       is_wr_q;
    logic       strobe_off;

    assign strobe_off = is_wr_q ? wr_s : rd_s;

    always_comb begin
        req.write   = rd_s;      // read has priority when both are seen
        req.waddr   = addr;
        req.lane_en = ~be_n;
        req.wdata   = wdata;
    end

    always_comb begin
        state_d   = state_q;
        req_valid = 1'b0;
        case (state_q)
            ST_IDLE:  if (!cs_s) state_d = ST_ARMED;
            ST_ARMED: begin
                if (cs_s) state_d = ST_IDLE;
                else if (!rd_s || !wr_s) begin
                    req_valid = 1'b1;
                    state_d   = ST_BUSY;
                end
            end
            ST_BUSY:  if (mem_ack) state_d = cs_s ? ST_IDLE : ST_DONE;
            ST_DONE: begin
                if (cs_s)            state_d = ST_IDLE;
                else if (strobe_off) state_d = ST_HOLD;
            end
            ST_HOLD:  if (cs_s) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            is_wr_q <= 1'b0;
            done_q  <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (req_valid) is_wr_q <= req.write;
            done_q  <= (state_d == ST_DONE) || (state_d == ST_HOLD);
            oe_q    <= (state_d == ST_DONE) && !(req_valid ? req.write : is_wr_q);
        end
    end
endmodule

// File: rtl/hbs_regfile.sv
module hbs_regfile
    import hbs_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int LAT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  hbs_req_t          req,
    input  logic [LAT_W-1:0]  cfg_lat,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    hbs_req_t          req_q;
    logic              pend_q;
    logic              ack_q;
    logic [LAT_W-1:0]  cnt_q;
    logic [LAT_W-1:0]  lat_eff;
    logic              fire;
    logic              hit;
    logic [IDX_W-1:0]  idx;

    assign lat_eff = (cfg_lat == '0) ? LAT_W'(1) : cfg_lat;
    assign fire    = pend_q && (cnt_q == LAT_W'(1));
    assign hit     = in_region(req_q.waddr, IDX_W);
    assign idx     = req_q.waddr[IDX_W-1:0];
    assign ack     = ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            ack_q  <= 1'b0;
            cnt_q  <= '0;
            req_q  <= '0;
        end else begin
            ack_q <= fire;
            if (req_valid && !pend_q) begin
                req_q  <= req;
                cnt_q  <= lat_eff;
                pend_q <= 1'b1;
            end else if (pend_q) begin
                if (fire) pend_q <= 1'b0;
                else      cnt_q  <= cnt_q - 1'b1;
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] store [DEPTH];
        logic [7:0] rd_lane_q;

        always_ff @(posedge clk) begin
            if (fire && req_q.write && hit && req_q.lane_en[g])
                store[idx] <= req_q.wdata[8*g +: 8];
        end

        always_ff @(posedge clk) begin
            if (rst)
                rd_lane_q <= '0;
            else if (fire && !req_q.write)
                rd_lane_q <= hit ? store[idx] : 8'h00;
        end

        assign rdata[8*g +: 8] = rd_lane_q;
    end
endmodule

// File: rtl/hbs_host_slave.sv
module hbs_host_slave
    import hbs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REG_BYTES   = 4096,
    parameter int LAT_W       = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   host_cs_n,
    input  logic [ADDR_HI:ADDR_LO] host_addr,
    input  logic [LANES-1:0]       host_be_n,
    input  logic                   host_rd_n,
    input  logic                   host_wr_n,
    inout  wire  [DATA_W-1:0]      host_data,
    output logic                   host_rdy,
    input  logic [LAT_W-1:0]       cfg_lat
);
    localparam int IDX_W = $clog2(REG_BYTES / (DATA_W / 8));

    logic              cs_s, rd_s, wr_s;
    logic              req_valid;
    hbs_req_t          req;
    logic              done_q, oe_q;
    hbs_state_e        fe_state;
    logic              mem_ack;
    logic [DATA_W-1:0] mem_rdata;
    logic              data_oe;

    hbs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({host_cs_n, host_rd_n, host_wr_n}),
        .q   ({cs_s, rd_s, wr_s})
    );

    hbs_frontend u_fe (
        .clk       (clk),
        .rst       (rst),
        .cs_s      (cs_s),
        .rd_s      (rd_s),
        .wr_s      (wr_s),
        .addr      (host_addr),
        .be_n      (host_be_n),
        .wdata     (host_data),
        .mem_ack   (mem_ack),
        .req_valid (req_valid),
        .req       (req),
        .done_q    (done_q),
        .oe_q      (oe_q),
        .state_q   (fe_state)
    );

    hbs_regfile #(.IDX_W(IDX_W), .LAT_W(LAT_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req       (req),
        .cfg_lat   (cfg_lat),
        .ack       (mem_ack),
        .rdata     (mem_rdata)
    );

    // Ready falls with chip select itself, not with its synchronized copy
    assign host_rdy  = host_cs_n | done_q;
    // Release the bus in the same cycle the host lets go
    assign data_oe   = oe_q & ~host_rd_n & ~host_cs_n;
    assign host_data = data_oe ? mem_rdata : 'z;
endmodule

// File: rtl/hbs_checker.sv
module hbs_checker
    import hbs_pkg::*;
#(
    parameter int LAT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             host_cs_n,
    input logic             host_wr_n,
    input logic             host_rdy,
    input logic             data_oe,
    input logic             cs_s,
    input logic             req_valid,
    input logic             mem_ack,
    input hbs_state_e       fe_state,
    input logic [LAT_W-1:0] cfg_lat
);
    logic [LAT_W:0]   cyc_q;
    logic [LAT_W-1:0] lat_q;
    logic [1:0]       reqs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q  <= '0;
            lat_q  <= '0;
            reqs_q <= '0;
        end else begin
            if (req_valid) begin
                cyc_q <= '0;
                lat_q <= (cfg_lat == '0) ? LAT_W'(1) : cfg_lat;
            end else if (!mem_ack) begin
                cyc_q <= cyc_q + 1'b1;
            end
            if (cs_s)                             reqs_q <= '0;
            else if (req_valid && reqs_q != 2'd3) reqs_q <= reqs_q + 1'b1;
        end
    end

    assert_wait_low_R1: assert property (@(posedge clk) disable iff (rst)
        (!host_cs_n && (fe_state == ST_ARMED || fe_state == ST_BUSY)) |-> !host_rdy);

    assert_ready_after_ack_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(host_rdy) && !host_cs_n) |-> $past(mem_ack));

    assert_no_drive_on_write_R5: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> host_wr_n);

    assert_single_access_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (reqs_q == 2'd0));

    assert_store_latency_R10: assert property (@(posedge clk) disable iff (rst)
        mem_ack |-> (cyc_q == {1'b0, lat_q}));
endmodule

bind hbs_host_slave hbs_checker #(.LAT_W(LAT_W)) u_hbs_checker (
    .clk       (clk),
    .rst       (rst),
    .host_cs_n (host_cs_n),
    .host_wr_n (host_wr_n),
    .host_rdy  (host_rdy),
    .data_oe   (data_oe),
    .cs_s      (cs_s),
    .req_valid (req_valid),
    .mem_ack   (mem_ack),
    .fe_state  (fe_state),
    .cfg_lat   (cfg_lat)
);

// File: tb/test_hbs_host_slave.sv
`timescale 1ns/1ps
module test_hbs_host_slave;
    localparam int SYNC = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_cs_n = 1'b1;
    logic [23:2] host_addr = '0;
    logic [3:0]  host_be_n = 4'hF;
    logic        host_rd_n = 1'b1;
    logic        host_wr_n = 1'b1;
    wire  [31:0] host_data;
    logic        host_rdy;
    logic [3:0]  cfg_lat = 4'd1;
    logic        tb_oe = 1'b0;
    logic [31:0] tb_val = '0;

    int checks = 0;
    int errors = 0;

    assign host_data = tb_oe ? tb_val : 'z;

    always #2 clk = ~clk;

    hbs_host_slave #(.SYNC_STAGES(SYNC)) i_hbs_host_slave (
        .clk       (clk),
        .rst       (rst),
        .host_cs_n (host_cs_n),
        .host_addr (host_addr),
        .host_be_n (host_be_n),
        .host_rd_n (host_rd_n),
        .host_wr_n (host_wr_n),
        .host_data (host_data),
        .host_rdy  (host_rdy),
        .cfg_lat   (cfg_lat)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One complete bus cycle; returns read data and edges until ready
    task automatic access(input logic rd, input logic [23:2] a, input logic [3:0] be,
                          input logic [31:0] wd, output logic [31:0] rdv, output int edges);
        @(negedge clk);
        host_cs_n = 1'b0;
        host_addr = a;
        host_be_n = be;
        #0.1;
        chk(host_rdy == 1'b0, "R1 ready low on select", {31'b0, host_rdy}, 32'h0);
        repeat (SYNC + 2) @(negedge clk);
        chk(host_rdy == 1'b0, "R1 ready held low", {31'b0, host_rdy}, 32'h0);
        if (rd) host_rd_n = 1'b0;
        else begin tb_val = wd; tb_oe = 1'b1; host_wr_n = 1'b0; end
        edges = 0;
        while (!host_rdy && edges < 64) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
        rdv = host_data;
        host_rd_n = 1'b1;
        host_wr_n = 1'b1;
        tb_oe = 1'b0;
        repeat (SYNC + 2) @(negedge clk);
        host_cs_n = 1'b1;
        repeat (SYNC + 2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(host_rdy == 1'b1, "R9 ready after reset", {31'b0, host_rdy}, 32'h1);
    endtask

    task automatic t_latency();
        logic [31:0] r;
        int e;
        int exp_l;
        logic [3:0] lats [4] = '{4'd1, 4'd7, 4'd15, 4'd0};
        for (int k = 0; k < 4; k++) begin
            cfg_lat = lats[k];
            exp_l = (lats[k] == 0) ? 1 : int'(lats[k]);
            access(1'b0, 22'(16 + k), 4'h0, 32'h5A00_0000 + 32'(k * 4097), r, e);
            chk(e == SYNC + exp_l + 2, "R3 write ready delay", 32'(e), 32'(SYNC + exp_l + 2));
            chk(e == SYNC + exp_l + 2, "R10 store latency", 32'(e), 32'(SYNC + exp_l + 2));
            access(1'b1, 22'(16 + k), 4'h0, 32'h0, r, e);
            chk(e == SYNC + exp_l + 2, "R3 read ready delay", 32'(e), 32'(SYNC + exp_l + 2));
            chk(r == 32'h5A00_0000 + 32'(k * 4097), "R2 read data", r, 32'h5A00_0000 + 32'(k * 4097));
        end
        cfg_lat = 4'd3;
    endtask

    task automatic t_lanes();
        logic [31:0] r;
        int e;
        access(1'b0, 22'd5, 4'h0, 32'h1122_3344, r, e);
        access(1'b0, 22'd5, 4'b1010, 32'hAABB_CCDD, r, e);
        access(1'b1, 22'd5, 4'h0, 32'h0, r, e);
        chk(r == 32'h11BB_33DD, "R4 lanes 0 and 2", r, 32'h11BB_33DD);
        access(1'b0, 22'd5, 4'b0111, 32'hEE00_0000, r, e);
        access(1'b1, 22'd5, 4'h0, 32'h0, r, e);
        chk(r == 32'hEEBB_33DD, "R4 lane 3 only", r, 32'hEEBB_33DD);
        access(1'b0, 22'd5, 4'hF, 32'h0000_0000, r, e);
        access(1'b1, 22'd5, 4'h0, 32'h0, r, e);
        chk(r == 32'hEEBB_33DD, "R4 no lanes enabled", r, 32'hEEBB_33DD);
        access(1'b0, 22'd6, 4'h0, 32'h8765_4321, r, e);
        access(1'b1, 22'd6, 4'h0, 32'h0, r, e);
        chk(r == 32'h8765_4321, "R5 write bus is input", r, 32'h8765_4321);
    endtask

    task automatic t_region();
        logic [31:0] r;
        int e;
        access(1'b0, 22'd0, 4'h0, 32'h0BAD_F00D, r, e);
        access(1'b0, 22'h000400, 4'h0, 32'hDEAD_BEEF, r, e);
        access(1'b1, 22'd0, 4'h0, 32'h0, r, e);
        chk(r == 32'h0BAD_F00D, "R7 outside write dropped", r, 32'h0BAD_F00D);
        access(1'b1, 22'h000400, 4'h0, 32'h0, r, e);
        chk(r == 32'h0, "R7 outside read zero", r, 32'h0);
        access(1'b1, 22'h3FFFFF, 4'h0, 32'h0, r, e);
        chk(r == 32'h0, "R7 top address read zero", r, 32'h0);
    endtask

    task automatic t_early_end();
        logic [31:0] r;
        int e;
        access(1'b0, 22'd3, 4'h0, 32'hCAFE_F00D, r, e);
        cfg_lat = 4'd15;
        @(negedge clk);
        host_cs_n = 1'b0;
        host_addr = 22'd3;
        host_be_n = 4'h0;
        repeat (SYNC + 2) @(negedge clk);
        host_rd_n = 1'b0;
        repeat (4) @(negedge clk);
        host_cs_n = 1'b1;
        #0.1;
        chk(host_rdy == 1'b1, "R6 ready after early end", {31'b0, host_rdy}, 32'h1);
        @(negedge clk);
        host_rd_n = 1'b1;
        repeat (30) @(negedge clk);
        chk(host_rdy == 1'b1, "R6 ready stays high", {31'b0, host_rdy}, 32'h1);
        access(1'b1, 22'd3, 4'h0, 32'h0, r, e);
        chk(r == 32'hCAFE_F00D, "R6 data intact", r, 32'hCAFE_F00D);
        chk(e == SYNC + 15 + 2, "R6 next access timing", 32'(e), 32'(SYNC + 17));
        cfg_lat = 4'd3;
    endtask

    task automatic t_single();
        logic [31:0] r;
        int e;
        @(negedge clk);
        host_cs_n = 1'b0;
        host_addr = 22'd9;
        host_be_n = 4'h0;
        repeat (SYNC + 2) @(negedge clk);
        tb_val = 32'h1111_AAAA; tb_oe = 1'b1; host_wr_n = 1'b0;
        repeat (20) @(negedge clk);
        host_wr_n = 1'b1; tb_oe = 1'b0;
        repeat (SYNC + 2) @(negedge clk);
        tb_val = 32'h2222_BBBB; tb_oe = 1'b1; host_wr_n = 1'b0;
        repeat (20) @(negedge clk);
        chk(host_rdy == 1'b1, "R8 ready on repeated strobe", {31'b0, host_rdy}, 32'h1);
        host_wr_n = 1'b1; tb_oe = 1'b0;
        repeat (SYNC + 2) @(negedge clk);
        host_cs_n = 1'b1;
        repeat (SYNC + 2) @(negedge clk);
        access(1'b1, 22'd9, 4'h0, 32'h0, r, e);
        chk(r == 32'h1111_AAAA, "R8 second strobe ignored", r, 32'h1111_AAAA);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_latency();
        t_lanes();
        t_region();
        t_early_end();
        t_single();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        finish_run();
    end
endmodule